// File: doc/BRIEF.md
# Banked DMA Channel Control Register Guard

This block holds one control word for each channel of a multi-channel DMA engine. It sits behind a coprocessor-style register port. A separate channel-select register decides which channel's word a control-register access reads or writes. Every access carries two attributes: the requester's security world (secure or non-secure) and its privilege level (privileged or user).

Before any data moves, the block screens each control-register access against two permission inputs. The first is a global enable that lets the non-secure world reach DMA registers. The second is a per-channel user-access bit, taken from the currently selected channel. A permitted access reads or writes the word. A refused access raises an undefined-instruction pulse and changes nothing.

The DMA datapath and the handling of the fault are outside this block.

Top module: `dma_chan_guard`

## Requirements
- R1: A secure privileged access (nonSecure=0, userMode=0) to the control word never faults, whatever nsDmaEn and the channel user bits hold.
- R2: A non-secure access to the control word is allowed only when nsDmaEn=1. A non-secure user access also needs chanUserEn of the selected channel to be 1.
- R3: A secure user access to the control word is allowed exactly when chanUserEn of the selected channel is 1, whatever nsDmaEn holds.
- R4: A refused access drives undefFault high in the same cycle as the accValid strobe, for that one cycle only. It leaves every control word unchanged and returns rdData = 0.
- R5: The control word keeps bit 26 (user-transfer flag), bits 19:8 (stride) and bits 1:0 (transfer size). All other bits read as 0, and writes to them are dropped.
- R6: After reset every channel's control word is 0 and the selected channel is 0.
- R7: The control word is reached at opc1=0, crn=11, crm=4, opc2=0, and the channel-select register at opc1=0, crn=11, crm=2, opc2=0. An access with any other encoding has no effect, returns 0 and never faults.
- R8: A read of the channel-select register returns the channel number in its low bits, with all other bits 0. A write of a value of NCH or more is ignored. Channel-select accesses are not screened.
- R9: A control-word write changes only the selected channel's word. A control-word read returns only the selected channel's word.
- R10: Read data is valid in the same cycle as the accValid strobe. A write is visible from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one cycle per access |
| accWrite | input | 1 | 1 = write, 0 = read |
| nonSecure | input | 1 | Requester is in the non-secure world |
| userMode | input | 1 | Requester is unprivileged |
| opc1 | input | 3 | Coprocessor opcode 1 |
| crn | input | 4 | Coprocessor primary register number |
| crm | input | 4 | Coprocessor secondary register number |
| opc2 | input | 3 | Coprocessor opcode 2 |
| wrData | input | 32 | Write data |
| nsDmaEn | input | 1 | Global non-secure DMA access enable |
| chanUserEn | input | NCH | User-access bit for each channel |
| rdData | output | 32 | Read data, 0 when nothing is read |
| undefFault | output | 1 | Undefined-instruction pulse for a refused access |

## Verification
The bench builds the block with its default NCH = 4. This makes the select field two bits wide, so every implemented channel can be reached. It also leaves values such as 4, 7 and 0x100 free to probe the rule that out-of-range selections are ignored. With four channels, the bench can write distinct words to neighbouring channels and show that the banks stay isolated. It then sweeps all sixteen combinations of world, privilege, global enable and user bit on one channel, for both reads and writes.

// File: rtl/dmacg_pkg.sv
package dmacg_pkg;
  localparam int DATA_W   = 32;
  localparam logic [3:0] REG_CRN = 4'd11;
  localparam logic [3:0] CTL_CRM = 4'd4;
  localparam logic [3:0] SEL_CRM = 4'd2;
  // kept bits: user-transfer flag 26, stride 19:8, size 1:0
  localparam logic [DATA_W-1:0] CTL_MASK = 32'h040F_FF03;

  typedef struct packed {
    logic wrCtl;
    logic rdCtl;
    logic wrSel;
    logic rdSel;
    logic fault;
  } strobe_t;
endpackage

// File: rtl/dmacg_ctrl.sv
module dmacg_ctrl
  import dmacg_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           accValid,
  input  logic           accWrite,
  input  logic           nonSecure,
  input  logic           userMode,
  input  logic [2:0]     opc1,
  input  logic [3:0]     crn,
  input  logic [3:0]     crm,
  input  logic [2:0]     opc2,
  input  logic           nsDmaEn,
  input  logic [NCH-1:0] chanUserEn,
  input  logic [CHW-1:0] curChan,
  output strobe_t        strb
);
  logic encBase, hitCtl, hitSel, uBit, allow;

  always_comb begin
    encBase = (opc1 == 3'd0) && (crn == REG_CRN) && (opc2 == 3'd0);
    hitCtl  = accValid && encBase && (crm == CTL_CRM);
    hitSel  = accValid && encBase && (crm == SEL_CRM);
    uBit    = chanUserEn[curChan];
    if (!nonSecure) allow = !userMode || uBit;
    else            allow = nsDmaEn && (!userMode || uBit);
    strb.wrCtl = hitCtl && allow && accWrite;
    strb.rdCtl = hitCtl && allow && !accWrite;
    strb.wrSel = hitSel && accWrite;
    strb.rdSel = hitSel && !accWrite;
    strb.fault = hitCtl && !allow;
  end

  // R1
  sp_never_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitCtl && !nonSecure && !userMode) |-> !strb.fault);
  // R2
  ns_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitCtl && nonSecure && !nsDmaEn) |-> strb.fault);
  // R3
  su_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitCtl && !nonSecure && userMode && !chanUserEn[curChan]) |-> strb.fault);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/dmacg_regs.sv
module dmacg_regs
  import dmacg_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CHW-1:0]    curChan,
  output logic [DATA_W-1:0] rdData
);
  logic [NCH-1:0][DATA_W-1:0] ctlWord;
  logic selInRange;

  assign selInRange = (wrData < DATA_W'(NCH));

  always_ff @(posedge clk) begin
    if (!rstN) curChan <= '0;
    else if (strb.wrSel && selInRange) curChan <= wrData[CHW-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) ctlWord[c] <= '0;
      else if (strb.wrCtl && (curChan == CHW'(c))) ctlWord[c] <= wrData & CTL_MASK;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdCtl)      rdData = ctlWord[curChan];
    else if (strb.rdSel) rdData = {{(DATA_W-CHW){1'b0}}, curChan};
  end

  // R4
  deny_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fault |=> $stable(ctlWord));
  // R8
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSel && !selInRange) |=> $stable(curChan));
  // R4
  deny_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fault |-> (rdData == '0));
endmodule

// File: rtl/dma_chan_guard.sv
module dma_chan_guard
  import dmacg_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           accValid,
  input  logic           accWrite,
  input  logic           nonSecure,
  input  logic           userMode,
  input  logic [2:0]     opc1,
  input  logic [3:0]     crn,
  input  logic [3:0]     crm,
  input  logic [2:0]     opc2,
  input  logic [31:0]    wrData,
  input  logic           nsDmaEn,
  input  logic [NCH-1:0] chanUserEn,
  output logic [31:0]    rdData,
  output logic           undefFault
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  strobe_t        strb;
  logic [CHW-1:0] curChan;

  dmacg_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .nonSecure(nonSecure), .userMode(userMode), .opc1(opc1), .crn(crn),
    .crm(crm), .opc2(opc2), .nsDmaEn(nsDmaEn), .chanUserEn(chanUserEn),
    .curChan(curChan), .strb(strb)
  );

  dmacg_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .curChan(curChan), .rdData(rdData)
  );

  assign undefFault = strb.fault;
endmodule

// File: tb/tb_dma_chan_guard.sv
module tb_dma_chan_guard;
  localparam int NCH = 4;
  localparam logic [31:0] MASK = 32'h040F_FF03;

  logic clk = 0, rstN = 0;
  logic accValid = 0, accWrite = 0, nonSecure = 0, userMode = 0;
  logic [2:0] opc1 = 0, opc2 = 0;
  logic [3:0] crn = 4'd11, crm = 4'd4;
  logic [31:0] wrData = 0;
  logic nsDmaEn = 0;
  logic [NCH-1:0] chanUserEn = 0;
  logic [31:0] rdData;
  logic undefFault;

  int nChecks = 0, nFails = 0;
  logic [31:0] model [NCH];
  int selM = 0;

  always #5 clk = ~clk;

  dma_chan_guard #(.NCH(NCH)) dut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic ns, input logic usr, input logic [3:0] cm,
                     input logic [31:0] d, output logic [31:0] rd, output logic flt);
    @(negedge clk);
    accValid = 1; accWrite = wr; nonSecure = ns; userMode = usr; crm = cm; wrData = d;
    #2; rd = rdData; flt = undefFault;
    @(posedge clk); #1;
    accValid = 0; accWrite = 0;
  endtask

  function automatic logic allowedM(input logic ns, input logic usr, input logic en, input logic u);
    return (!ns && (!usr || u)) || (ns && en && (!usr || u));
  endfunction

  logic [31:0] r; logic f;

  task automatic selectChan(input int c);
    acc(1, 0, 0, 4'd2, c, r, f);
    if (c < NCH) selM = c;
  endtask

  task automatic testReset();
    acc(0, 0, 0, 4'd2, 0, r, f);
    check("R6 select after reset", r, 0);
    for (int c = 0; c < NCH; c++) begin
      selectChan(c);
      acc(0, 0, 0, 4'd4, 0, r, f);
      check("R6 control word after reset", r, 0);
    end
  endtask

  task automatic testFields();
    selectChan(0);
    acc(1, 0, 0, 4'd4, 32'hFFFF_FFFF, r, f);
    model[0] = MASK;
    check("R5 write fault", {31'b0, f}, 0);
    acc(0, 0, 0, 4'd4, 0, r, f);
    check("R5 field mask readback", r, MASK);
    acc(1, 0, 0, 4'd4, 32'h0000_0000, r, f);
    model[0] = 0;
    acc(0, 0, 0, 4'd4, 0, r, f);
    check("R10 next-cycle write visible", r, 0);
  endtask

  task automatic testBanks();
    selectChan(1); acc(1, 0, 0, 4'd4, 32'h0400_1201, r, f); model[1] = 32'h0400_1201;
    selectChan(2); acc(1, 0, 0, 4'd4, 32'h000A_B802, r, f); model[2] = 32'h000A_B802;
    for (int c = 0; c < 3; c++) begin
      selectChan(c);
      acc(0, 0, 0, 4'd4, 0, r, f);
      check("R9 banked readback", r, model[c]);
    end
  endtask

  task automatic testMatrix();
    selectChan(3);
    for (int i = 0; i < 16; i++) begin
      logic ns, usr, en, u, ok;
      logic [31:0] v;
      ns = i[0]; usr = i[1]; en = i[2]; u = i[3];
      nsDmaEn = en; chanUserEn = '0; chanUserEn[3] = u;
      ok = allowedM(ns, usr, en, u);
      v = ((32'(i) << 8) | 32'(i & 3) | ((i & 1) ? 32'h0400_0000 : 0)) ^ 32'h0000_5500;
      acc(1, ns, usr, 4'd4, v, r, f);
      check(ns ? "R2 write fault" : (usr ? "R3 write fault" : "R1 write fault"),
            {31'b0, f}, {31'b0, !ok});
      if (ok) model[3] = v & MASK;
      acc(0, ns, usr, 4'd4, 0, r, f);
      check("R4 read fault flag", {31'b0, f}, {31'b0, !ok});
      check("R4 read data", r, ok ? model[3] : 32'h0);
      @(negedge clk);
      check("R4 fault single cycle", {31'b0, undefFault}, 0);
      acc(0, 0, 0, 4'd4, 0, r, f);
      check("R4 contents after access", r, model[3]);
    end
    nsDmaEn = 0; chanUserEn = '0;
  endtask

  task automatic testSelRange();
    selectChan(2);
    selectChan(4);
    acc(0, 0, 0, 4'd2, 0, r, f);
    check("R8 out-of-range 4 ignored", r, 2);
    selectChan(32'h100);
    acc(0, 1, 1, 4'd2, 0, r, f);
    check("R8 unscreened read ns user", r, 2);
    check("R8 select no fault", {31'b0, f}, 0);
    acc(1, 1, 1, 4'd2, 3, r, f); selM = 3;
    acc(0, 0, 0, 4'd2, 0, r, f);
    check("R8 unscreened write", r, 3);
  endtask

  task automatic testEncoding();
    selectChan(1);
    acc(1, 0, 0, 4'd5, 32'h0000_0003, r, f);
    check("R7 other encoding no fault", {31'b0, f}, 0);
    acc(0, 1, 1, 4'd5, 0, r, f);
    check("R7 other encoding reads zero", r, 0);
    check("R7 other encoding denied world no fault", {31'b0, f}, 0);
    @(negedge clk); opc2 = 3'd1;
    acc(1, 0, 0, 4'd4, 32'h0000_0002, r, f);
    @(negedge clk); opc2 = 3'd0;
    acc(0, 0, 0, 4'd4, 0, r, f);
    check("R7 control word untouched", r, model[1]);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testFields();
    testBanks();
    testMatrix();
    testSelRange();
    testEncoding();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule